// File: doc/BRIEF.md
# Bus Transceiver Control Generator

This block drives two control lines for the external data transceivers that sit between the memory controller and the system data bus. At the start of each memory-controller operation it reads which memory machine owns the bank (general-purpose, user-programmable or SDRAM) and the bank's disable bit. From these it decides whether the transceivers take part in the access. Once a qualifying access starts, the lines stay active until the final partial-data-valid beat of that access. The exception is a following operation already queued back-to-back: in that case the lines are not released between the two operations.

A static configuration input picks how the two lines are encoded. With the input low, both lines are active-high: line 0 is a direction indicator, high for a write, and line 1 is an output enable. With the input high, both lines are inverted, so they are active-low. Both lines come straight from flip-flops clocked on the bus clock.

Top module: `bctl_gen`

## Requirements
- R1: While `rst_n` is low and while no qualifying access is in progress, both lines sit at the inactive level: `00` with `cfg_inv_i`=0 and `11` with `cfg_inv_i`=1.
- R2: The clock edge that samples `op_start_i` high activates the lines when `op_mach_i` is 0 (general-purpose) or 1 (user-programmable) and `bank_dis_i` is 0. With `cfg_inv_i`=0, bit 1 (enable) goes to 1 and bit 0 (direction) takes the value of `op_write_i`.
- R3: A start with `op_mach_i`=2 (SDRAM) never activates the lines. The reserved code 3 behaves the same way.
- R4: A start with `bank_dis_i`=1 never activates the lines, whatever the machine code.
- R5: With `cfg_inv_i`=1, each line is the complement of its `cfg_inv_i`=0 value, in both the active and the idle state.
- R6: During an active access, the edge that samples `pdval_i`=1 together with `last_beat_i`=1, `next_pend_i`=0 and `op_start_i`=0 returns both lines to the inactive level. Earlier `pdval_i` beats, sampled with `last_beat_i`=0, leave the lines active.
- R7: When that final beat is sampled with `next_pend_i`=1, the lines stay active. They remain active until the next start, which then sets the direction from its own `op_write_i`.
- R8: `last_beat_i` sampled without `pdval_i` has no effect on the lines.
- R9: A start that does not qualify under R3 or R4, arriving while the lines are held active, returns them to the inactive level.
- R10: The direction bit keeps the value captured at the start for the whole access. Later changes of `op_write_i` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_inv_i | input | 1 | Encoding select: 0 active-high, 1 active-low |
| op_start_i | input | 1 | First cycle of a memory-controller operation |
| op_mach_i | input | 2 | Owning machine: 0 general-purpose, 1 user-programmable, 2 SDRAM, 3 reserved |
| op_write_i | input | 1 | Access is a write (sampled at start) |
| bank_dis_i | input | 1 | Per-bank transceiver-control disable |
| pdval_i | input | 1 | Partial data valid strobe |
| last_beat_i | input | 1 | Current strobe is the last of the access |
| next_pend_i | input | 1 | Another operation follows back-to-back |
| bctl_o | output | 2 | Bit 0 direction, bit 1 enable |

## Verification
Every result is due one clock edge after the edge that samples its cause. That cause can be a start, a final data beat, a change of the encoding select, or reset. The bench changes inputs 2 ns after a rising edge and compares `bctl_o` 2 ns after the next rising edge, so each comparison sees exactly one register update. The sweep covers every combination of encoding, machine code, bank disable and direction, with burst lengths of one to three beats. Separate back-to-back chains check that the lines are held across a pending operation and released by a start that does not qualify.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

    localparam int MACH_W  = 2;
    localparam int CTL_N   = 2;
    localparam int CTL_DIR = 0;
    localparam int CTL_EN  = 1;

    typedef enum logic [MACH_W-1:0] {
        MACH_GP    = 2'd0,
        MACH_UP    = 2'd1,
        MACH_SDRAM = 2'd2,
        MACH_RSV   = 2'd3
    } mach_e;

    typedef struct packed {
        logic active;
        logic wr;
    } span_t;

    typedef struct packed {
        logic [CTL_N-1:0] ctl;
    } out_t;

endpackage

// File: rtl/bctl_qualify.sv
module bctl_qualify
    import bctl_pkg::*;
(
    input  mach_e mach_i,
    input  logic  bank_dis_i,
    output logic  elig_o
);

    logic mach_ok;

    always_comb begin
        unique case (mach_i)
            MACH_GP, MACH_UP: mach_ok = 1'b1;
            default:          mach_ok = 1'b0;
        endcase
        elig_o = mach_ok & ~bank_dis_i;
    end

endmodule

// File: rtl/bctl_span.sv
module bctl_span
    import bctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic elig_i,
    input  logic wr_i,
    input  logic pdval_i,
    input  logic last_i,
    input  logic pend_i,
    output logic active_d_o,
    output logic wr_d_o,
    output logic active_q_o,
    output logic wr_q_o
);

    span_t st_d, st_q;
    logic  final_beat;

    always_comb begin
        st_d       = st_q;
        final_beat = pdval_i & last_i;
        if (start_i) begin
            st_d.active = elig_i;
            st_d.wr     = elig_i & wr_i;
        end else if (st_q.active && final_beat && !pend_i) begin
            st_d.active = 1'b0;
            st_d.wr     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_d_o = st_d.active;
    assign wr_d_o     = st_d.wr;
    assign active_q_o = st_q.active;
    assign wr_q_o     = st_q.wr;

    // R6
    release_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start_i && pdval_i && last_i && !pend_i) |=> !st_q.active);

    // R7
    hold_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start_i && pdval_i && last_i && pend_i) |=> st_q.active);

    // R8 R10
    mid_access_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !start_i && !(pdval_i && last_i)) |=> (st_q.active && $stable(st_q.wr)));

    // R9
    reject_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !elig_i) |=> !st_q.active);

endmodule

// File: rtl/bctl_encode.sv
module bctl_encode
    import bctl_pkg::*;
(
    input  logic             active_i,
    input  logic             wr_i,
    input  logic             inv_i,
    output logic [CTL_N-1:0] ctl_o
);

    for (genvar g = 0; g < CTL_N; g++) begin : g_ctl
        if (g == CTL_DIR) begin : g_dir
            always_comb ctl_o[g] = (active_i & wr_i) ^ inv_i;
        end else begin : g_en
            always_comb ctl_o[g] = active_i ^ inv_i;
        end
    end

endmodule

// File: rtl/bctl_gen.sv
module bctl_gen
    import bctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inv_i,
    input  logic              op_start_i,
    input  logic [MACH_W-1:0] op_mach_i,
    input  logic              op_write_i,
    input  logic              bank_dis_i,
    input  logic              pdval_i,
    input  logic              last_beat_i,
    input  logic              next_pend_i,
    output logic [CTL_N-1:0]  bctl_o
);

    logic             elig;
    logic             act_d, wr_d, act_q, wr_q;
    logic [CTL_N-1:0] ctl_next;
    out_t             out_d, out_q;

    bctl_qualify u_qualify (
        .mach_i     (mach_e'(op_mach_i)),
        .bank_dis_i (bank_dis_i),
        .elig_o     (elig)
    );

    bctl_span u_span (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (op_start_i),
        .elig_i     (elig),
        .wr_i       (op_write_i),
        .pdval_i    (pdval_i),
        .last_i     (last_beat_i),
        .pend_i     (next_pend_i),
        .active_d_o (act_d),
        .wr_d_o     (wr_d),
        .active_q_o (act_q),
        .wr_q_o     (wr_q)
    );

    bctl_encode u_encode (
        .active_i (act_d),
        .wr_i     (wr_d),
        .inv_i    (cfg_inv_i),
        .ctl_o    (ctl_next)
    );

    always_comb begin
        out_d     = out_q;
        out_d.ctl = ctl_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.ctl <= {CTL_N{cfg_inv_i}};
        end else begin
            out_q <= out_d;
        end
    end

    assign bctl_o = out_q.ctl;

    // R1 R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && $stable(cfg_inv_i)) |-> (bctl_o == {CTL_N{cfg_inv_i}}));

    // R2
    enable_tracks_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_inv_i) |-> ((bctl_o[CTL_EN] ^ cfg_inv_i) == act_q));

    // R10
    dir_tracks_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && $stable(cfg_inv_i)) |-> ((bctl_o[CTL_DIR] ^ cfg_inv_i) == wr_q));

    // R3
    sdram_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start_i && op_mach_i == MACH_SDRAM) |=> !act_q);

    // R4
    bank_dis_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start_i && bank_dis_i) |=> !act_q);

endmodule

// File: tb/bctl_gen_bench.sv
module bctl_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_inv;
    logic       op_start;
    logic [1:0] op_mach;
    logic       op_write;
    logic       bank_dis;
    logic       pdval;
    logic       last_beat;
    logic       next_pend;
    logic [1:0] bctl_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bctl_gen u_bctl_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_inv_i   (cfg_inv),
        .op_start_i  (op_start),
        .op_mach_i   (op_mach),
        .op_write_i  (op_write),
        .bank_dis_i  (bank_dis),
        .pdval_i     (pdval),
        .last_beat_i (last_beat),
        .next_pend_i (next_pend),
        .bctl_o      (bctl_o)
    );

    function automatic logic [1:0] expo(bit inv, bit en, bit wr);
        return {en ^ inv, (en & wr) ^ inv};
    endfunction

    task automatic chk(string tag, logic [1:0] exp);
        n_chk++;
        if (bctl_o !== exp) begin
            n_bad++;
            $display("FAIL %s: bctl_o=%b expected=%b", tag, bctl_o, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_in;
        op_start  = 1'b0;
        pdval     = 1'b0;
        last_beat = 1'b0;
        next_pend = 1'b0;
    endtask

    task automatic start_op(int mach, bit dis, bit wr);
        op_start = 1'b1;
        op_mach  = 2'(mach);
        bank_dis = dis;
        op_write = wr;
        tick();
        op_start = 1'b0;
    endtask

    task automatic run_txn(bit inv, int mach, bit dis, bit wr, int beats);
        bit    en;
        string tag;
        idle_in();
        cfg_inv = inv;
        tick();
        chk("R1 R5 idle", expo(inv, 1'b0, 1'b0));
        en  = (mach < 2) && !dis;
        tag = en ? (inv ? "R5 start" : "R2 start") : (dis ? "R4 start" : "R3 start");
        start_op(mach, dis, wr);
        chk(tag, expo(inv, en, wr));
        // R8 R10: lone last_beat and a flipped write request change nothing
        op_write  = ~wr;
        last_beat = 1'b1;
        tick();
        chk("R8 R10 hold", expo(inv, en, wr));
        last_beat = 1'b0;
        for (int b = 1; b <= beats; b++) begin
            pdval     = 1'b1;
            last_beat = (b == beats);
            tick();
            chk("R6 beat", expo(inv, en && (b < beats), wr));
        end
        idle_in();
    endtask

    task automatic chain(bit inv, bit wr1, int mach2, bit dis2, bit wr2);
        bit en2;
        idle_in();
        cfg_inv = inv;
        tick();
        start_op(1, 1'b0, wr1);
        chk("R2 chain start", expo(inv, 1'b1, wr1));
        pdval     = 1'b1;
        last_beat = 1'b1;
        next_pend = 1'b1;
        tick();
        chk("R7 pending hold", expo(inv, 1'b1, wr1));
        idle_in();
        tick();
        chk("R7 gap hold", expo(inv, 1'b1, wr1));
        en2 = (mach2 < 2) && !dis2;
        start_op(mach2, dis2, wr2);
        chk(en2 ? "R7 next start" : "R9 reject", expo(inv, en2, wr2));
        pdval     = 1'b1;
        last_beat = 1'b1;
        tick();
        chk("R6 chain end", expo(inv, 1'b0, 1'b0));
        idle_in();
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        cfg_inv  = 1'b1;
        op_mach  = 2'd0;
        op_write = 1'b0;
        bank_dis = 1'b0;
        idle_in();
        tick();
        tick();
        chk("R1 reset inv", 2'b11);
        cfg_inv = 1'b0;
        op_start = 1'b1;
        tick();
        chk("R1 reset plain", 2'b00);
        op_start = 1'b0;
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", 2'b00);

        for (int inv = 0; inv < 2; inv++)
            for (int mach = 0; mach < 4; mach++)
                for (int dis = 0; dis < 2; dis++)
                    for (int wr = 0; wr < 2; wr++)
                        run_txn(inv[0], mach, dis[0], wr[0], 1 + (mach + wr) % 3);

        for (int inv = 0; inv < 2; inv++) begin
            chain(inv[0], 1'b1, 0, 1'b0, 1'b0);
            chain(inv[0], 1'b0, 1, 1'b0, 1'b1);
            chain(inv[0], 1'b1, 2, 1'b0, 1'b1);
            chain(inv[0], 1'b0, 0, 1'b1, 1'b1);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule